// File: doc/BRIEF.md
# Modem Line Change Monitor

This block watches four asynchronous modem handshake inputs (clear-to-send, data-set-ready, ring and carrier detect), brings them into the clock domain, and reports their present levels through a status word. Each line has a sticky change flag. A delta interrupt request stays high while any flag is set. Software clears a flag by writing a one to its bit.

The same block holds the modem control outputs: data-terminal-ready and request-to-send, both driven active-low at the pins. It also holds an automatic flow-control enable, plus a flow-control mode bit that sits in the status word. Register access is a plain single-cycle write strobe with a combinational read mux. The control word is at offset 0x24 and the status word at offset 0x28.

Top module: `modem_delta_unit`

## Requirements
- R1: After reset all change flags, control bits and the flow mode bit read zero, both pin outputs (`dtr_pin_n`, `rts_pin_n`) are high and `delta_irq` is low.
- R2: Status word bits report the synchronized levels: carrier at bit 7, ring at bit 6, data-set-ready at bit 5 and clear-to-send at bit 4. An input change present before clock edge k reads back after edge k+1, and not after edge k.
- R3: The change flags for clear-to-send (bit 0), data-set-ready (bit 1) and carrier (bit 3) set on either a rising or a falling edge. The flag is set after edge k+2 for an input change before edge k, and it then holds.
- R4: The ring flag (bit 2) sets only when ring goes from high to low. A low-to-high ring transition leaves it clear.
- R5: Writing the status word clears each flag whose bit 3..0 is one. A zero in a bit leaves that flag unchanged.
- R6: When a clear write and a new edge on the same line meet in one cycle, the flag stays set.
- R7: `delta_irq` is high exactly while at least one flag is set. Clearing some of the flags while others remain keeps it high.
- R8: The control word at 0x24 holds data-terminal-ready at bit 0, request-to-send at bit 1 and the automatic flow-control enable at bit 5. It reads back only those bits. The pins drive the inverse of bits 0 and 1, and `autoflow_en` follows bit 5.
- R9: Status word bit 8 is a read/write flow-control mode bit, driven on `flow_mode`.
- R10: Writes to unmapped addresses change nothing, and reads of them return zero. Writes to status bits 7..4 do not alter the reported levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_cts | input | 1 | Asynchronous clear-to-send level |
| line_dsr | input | 1 | Asynchronous data-set-ready level |
| line_ri | input | 1 | Asynchronous ring level |
| line_dcd | input | 1 | Asynchronous carrier detect level |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| dtr_pin_n | output | 1 | Data-terminal-ready, active low |
| rts_pin_n | output | 1 | Request-to-send, active low |
| autoflow_en | output | 1 | Automatic flow-control enable |
| flow_mode | output | 1 | Flow-control mode bit |
| delta_irq | output | 1 | Modem change interrupt request |

## Verification
A line change is due on the level bits two edges after it is applied. It is due on the flag and on `delta_irq` one edge later. Register writes take effect at the single edge that follows the strobe. The bench changes inputs only between edges and reads the status word once per cycle. It therefore expects the old value at the first two reads after a line change, the new level at the third, and the flag at the fourth. The coincidence case schedules the clear write so that it lands on exactly the edge where the edge detector fires.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NUM_LINES = 4;

  // line index == flag bit position, level bit = index + STAT_LVL_LSB
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  localparam int STAT_FLAG_LSB = 0;
  localparam int STAT_LVL_LSB  = 4;
  localparam int STAT_FLOW_BIT = 8;

  localparam int CTRL_DTR_BIT  = 0;
  localparam int CTRL_RTS_BIT  = 1;
  localparam int CTRL_AUTO_BIT = 5;

  typedef enum logic [0:0] {
    EDGE_ANY  = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  function automatic edge_kind_e line_edge_kind(input int idx);
    return (idx == LN_RI) ? EDGE_FALL : EDGE_ANY;
  endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = async_i;
    end else begin : g_rest
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_delta_flags.sv
module mdm_delta_flags
  import mdm_pkg::*;
#(
  parameter int LINES = NUM_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] flag_o
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] evt;
  logic [LINES-1:0] flag_d;
  logic [LINES-1:0] flag_en;
  logic [LINES-1:0] flag_q;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (line_edge_kind(i) == EDGE_FALL) begin : g_fall
      assign evt[i] = prev_q[i] & ~lvl_i[i];
    end else begin : g_any
      assign evt[i] = prev_q[i] ^ lvl_i[i];
    end
  end

  // a detected edge wins over a clear in the same cycle
  always_comb begin
    flag_en = evt | clr_i;
    flag_d  = evt | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      for (int b = 0; b < LINES; b++) begin
        if (flag_en[b]) flag_q[b] <= flag_d[b];
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mdm_ctrl_regs.sv
module mdm_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic stat_we,
  input  logic dtr_wr,
  input  logic rts_wr,
  input  logic auto_wr,
  input  logic flow_wr,
  output logic dtr_o,
  output logic rts_o,
  output logic auto_o,
  output logic flow_o
);
  logic [2:0] ctrl_q, ctrl_d;
  logic       flow_q, flow_d;

  always_comb begin
    ctrl_d = {auto_wr, rts_wr, dtr_wr};
    flow_d = flow_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flow_q <= 1'b0;
    else if (stat_we) flow_q <= flow_d;
  end

  assign dtr_o  = ctrl_q[0];
  assign rts_o  = ctrl_q[1];
  assign auto_o = ctrl_q[2];
  assign flow_o = flow_q;
endmodule

// File: rtl/modem_delta_unit.sv
module modem_delta_unit
  import mdm_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 32,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h24,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_cts,
  input  logic              line_dsr,
  input  logic              line_ri,
  input  logic              line_dcd,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dtr_pin_n,
  output logic              rts_pin_n,
  output logic              autoflow_en,
  output logic              flow_mode,
  output logic              delta_irq
);
  localparam int FLAG_MSB = STAT_FLAG_LSB + NUM_LINES - 1;
  localparam int LVL_MSB  = STAT_LVL_LSB + NUM_LINES - 1;

  // reset: asserted asynchronously, released after two edges
  logic rst_meta_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [NUM_LINES-1:0] line_raw;
  logic [NUM_LINES-1:0] lvl_sync;
  logic [NUM_LINES-1:0] flag_q;
  logic [NUM_LINES-1:0] clr_mask;

  always_comb begin
    line_raw         = '0;
    line_raw[LN_CTS] = line_cts;
    line_raw[LN_DSR] = line_dsr;
    line_raw[LN_RI]  = line_ri;
    line_raw[LN_DCD] = line_dcd;
  end

  mdm_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (line_raw),
    .sync_o  (lvl_sync)
  );

  logic ctrl_we, stat_we;

  always_comb begin
    ctrl_we  = reg_wr_en && (reg_addr == CTRL_OFS);
    stat_we  = reg_wr_en && (reg_addr == STAT_OFS);
    clr_mask = stat_we ? reg_wdata[FLAG_MSB:STAT_FLAG_LSB] : '0;
  end

  mdm_delta_flags #(
    .LINES (NUM_LINES)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .lvl_i  (lvl_sync),
    .clr_i  (clr_mask),
    .flag_o (flag_q)
  );

  logic dtr_q, rts_q, auto_q, flow_q;

  mdm_ctrl_regs u_ctrl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ctrl_we (ctrl_we),
    .stat_we (stat_we),
    .dtr_wr  (reg_wdata[CTRL_DTR_BIT]),
    .rts_wr  (reg_wdata[CTRL_RTS_BIT]),
    .auto_wr (reg_wdata[CTRL_AUTO_BIT]),
    .flow_wr (reg_wdata[STAT_FLOW_BIT]),
    .dtr_o   (dtr_q),
    .rts_o   (rts_q),
    .auto_o  (auto_q),
    .flow_o  (flow_q)
  );

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[DATA_W-1:STAT_FLOW_BIT+1],
                          reg_wdata[LVL_MSB:STAT_LVL_LSB]};

  logic [DATA_W-1:0] ctrl_word, stat_word;

  always_comb begin
    ctrl_word                 = '0;
    ctrl_word[CTRL_DTR_BIT]   = dtr_q;
    ctrl_word[CTRL_RTS_BIT]   = rts_q;
    ctrl_word[CTRL_AUTO_BIT]  = auto_q;

    stat_word                               = '0;
    stat_word[FLAG_MSB:STAT_FLAG_LSB]       = flag_q;
    stat_word[LVL_MSB:STAT_LVL_LSB]         = lvl_sync;
    stat_word[STAT_FLOW_BIT]                = flow_q;

    if (reg_addr == CTRL_OFS)      reg_rdata = ctrl_word;
    else if (reg_addr == STAT_OFS) reg_rdata = stat_word;
    else                           reg_rdata = '0;
  end

  assign dtr_pin_n   = ~dtr_q;
  assign rts_pin_n   = ~rts_q;
  assign autoflow_en = auto_q;
  assign flow_mode   = flow_q;
  assign delta_irq   = |flag_q;
endmodule

// File: rtl/modem_delta_unit_chk.sv
module modem_delta_unit_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h24,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              dtr_pin_n,
  input logic              rts_pin_n,
  input logic              delta_irq,
  input logic [3:0]        lvl_sync,
  input logic [3:0]        flag_q
);
  logic ctrl_wr, stat_wr;
  assign ctrl_wr = reg_wr_en && (reg_addr == CTRL_OFS);
  assign stat_wr = reg_wr_en && (reg_addr == STAT_OFS);

  assert_dtr_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (dtr_pin_n == !$past(reg_wdata[0])));

  assert_rts_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(rts_pin_n));

  assert_cts_flag_on_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> ($past(lvl_sync[0], 2) != $past(lvl_sync[0], 1)));

  assert_ring_trailing_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[2]) |-> ($past(lvl_sync[2], 2) && !$past(lvl_sync[2], 1)));

  assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flag_q) && !stat_wr) |=> delta_irq);

  assert_irq_drop_needs_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(delta_irq) |-> $past(stat_wr && (|reg_wdata[3:0])));
endmodule

bind modem_delta_unit modem_delta_unit_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CTRL_OFS (CTRL_OFS),
  .STAT_OFS (STAT_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .dtr_pin_n (dtr_pin_n),
  .rts_pin_n (rts_pin_n),
  .delta_irq (delta_irq),
  .lvl_sync  (lvl_sync),
  .flag_q    (flag_q)
);

// File: tb/modem_delta_unit_bench.sv
module modem_delta_unit_bench;
  localparam logic [7:0] A_CTRL = 8'h24;
  localparam logic [7:0] A_STAT = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_cts, line_dsr, line_ri, line_dcd;
  logic        reg_wr_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        dtr_pin_n, rts_pin_n, autoflow_en, flow_mode, delta_irq;

  always #2 clk = ~clk;

  modem_delta_unit u_modem_delta_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_cts    (line_cts),
    .line_dsr    (line_dsr),
    .line_ri     (line_ri),
    .line_dcd    (line_dcd),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .dtr_pin_n   (dtr_pin_n),
    .rts_pin_n   (rts_pin_n),
    .autoflow_en (autoflow_en),
    .flow_mode   (flow_mode),
    .delta_irq   (delta_irq)
  );

  typedef struct {
    string       tag;
    bit          is_pins;
    logic [31:0] exp;
  } item_t;

  item_t sb_q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // monitor: compares between edges, one ns after the driver's negedge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_pins ? {27'd0, delta_irq, flow_mode, autoflow_en, rts_pin_n, dtr_pin_n}
                         : reg_rdata;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic chk_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    reg_addr   = a;
    it.tag     = tag;
    it.is_pins = 1'b0;
    it.exp     = e;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  // pin vector: {irq, flow, autoflow, rts_n, dtr_n}
  task automatic chk_pins(input logic [4:0] e, input string tag);
    item_t it;
    it.tag     = tag;
    it.is_pins = 1'b1;
    it.exp     = {27'd0, e};
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    line_cts = 0; line_dsr = 0; line_ri = 0; line_dcd = 0;
    reg_wr_en = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    chk_reg(A_CTRL, 32'h0, "R1 ctrl after reset");
    chk_reg(A_STAT, 32'h0, "R1 status after reset");
    chk_pins(5'b00011, "R1 pins after reset");

    wr(A_CTRL, 32'h23);
    chk_reg(A_CTRL, 32'h23, "R8 ctrl readback");
    chk_pins(5'b00100, "R8 pins low, autoflow");
    wr(A_CTRL, 32'hFFFF_FFFF);
    chk_reg(A_CTRL, 32'h23, "R8 only defined bits stored");
    wr(A_CTRL, 32'h01);
    wr(A_STAT, 32'h100);
    chk_reg(A_STAT, 32'h100, "R9 flow bit readback");
    chk_pins(5'b01010, "R9 flow_mode pin, R8 dtr only");

    line_cts = 1'b1;
    chk_reg(A_STAT, 32'h100, "R2 level not before edge");
    chk_reg(A_STAT, 32'h100, "R2 level not after one edge");
    chk_reg(A_STAT, 32'h110, "R2 level after two edges");
    chk_reg(A_STAT, 32'h111, "R3 cts rise flag after three edges");
    chk_pins(5'b11010, "R7 irq with flag");

    wr(A_STAT, 32'h100);
    chk_reg(A_STAT, 32'h111, "R5 zero write keeps flag");
    wr(A_STAT, 32'h101);
    chk_reg(A_STAT, 32'h110, "R5 one clears flag");
    chk_pins(5'b01010, "R7 irq drops after clear");

    line_cts = 1'b0;
    repeat (3) tick();
    chk_reg(A_STAT, 32'h101, "R3 cts fall flag");
    wr(A_STAT, 32'h101);
    chk_reg(A_STAT, 32'h100, "R5 cts flag cleared");

    line_ri = 1'b1;
    repeat (3) tick();
    chk_reg(A_STAT, 32'h140, "R4 ring rise no flag");
    chk_pins(5'b01010, "R4 ring rise no irq");
    line_ri = 1'b0;
    repeat (3) tick();
    chk_reg(A_STAT, 32'h104, "R4 ring trailing edge flag");
    chk_pins(5'b11010, "R7 irq on ring flag");
    wr(A_STAT, 32'h104);
    chk_reg(A_STAT, 32'h100, "R5 ring flag cleared");

    line_dsr = 1'b1; line_dcd = 1'b1;
    repeat (3) tick();
    chk_reg(A_STAT, 32'h1AA, "R3 dsr and dcd rise flags");
    wr(A_STAT, 32'h102);
    chk_reg(A_STAT, 32'h1A8, "R5 clear only dsr flag");
    chk_pins(5'b11010, "R7 irq stays with one flag left");
    wr(A_STAT, 32'h108);
    chk_reg(A_STAT, 32'h1A0, "R5 dcd flag cleared");
    chk_pins(5'b01010, "R7 irq low when all clear");

    line_dsr = 1'b0;
    repeat (3) tick();
    chk_reg(A_STAT, 32'h182, "R3 dsr fall flag");
    line_dcd = 1'b0;
    tick();
    tick();
    wr(A_STAT, 32'h108);
    chk_reg(A_STAT, 32'h10A, "R6 edge beats same-cycle clear");
    wr(A_STAT, 32'h10F);
    chk_reg(A_STAT, 32'h100, "R5 clear all flags");

    wr(8'h2C, 32'hFFF);
    chk_reg(A_CTRL, 32'h01, "R10 unmapped write leaves ctrl");
    chk_reg(A_STAT, 32'h100, "R10 unmapped write leaves status");
    chk_reg(8'h2C, 32'h0, "R10 unmapped read zero");
    wr(A_STAT, 32'h1F0);
    chk_reg(A_STAT, 32'h100, "R10 level bits not writable");

    wr(A_STAT, 32'h0);
    chk_pins(5'b00010, "R9 flow bit cleared");

    wr(A_CTRL, 32'h23);
    rst_n = 1'b0;
    chk_pins(5'b00011, "R1 pins on mid-run reset");
    chk_reg(A_CTRL, 32'h0, "R1 ctrl on mid-run reset");
    rst_n = 1'b1;
    repeat (4) tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule